// File: doc/BRIEF.md
# Five-Wire Audio Link Frame Controller

This block is the controller end of a five-wire, codec-clocked audio link. The codec supplies the bit clock, and every register in the block runs from that clock. The block drives the active-low link reset, the frame sync and the playback data line. It samples the capture data line.

After reset the block holds the link reset low for a fixed number of bit clocks and then releases it. Frames start on the next bit clock and then run back to back. Each frame is 256 bit clocks long: a 16-bit tag slot followed by twelve 20-bit data slots, all sent MSB first.

The tag slot is built from a per-slot valid mask, and slots that are not marked valid go out as zeros. Outgoing data is captured in parallel when each frame starts. Each complete incoming frame is presented in parallel together with a one-cycle frame-done strobe.

Top module: `slotlink_ctrl`

## Requirements
- R1: While `rst` is high, at every rising bit clock edge, `link_rst_n`, `sync`, `sdo` and `frame_done` go low, `rx_tag` and `rx_data` clear to zero, and the frame position clears.
- R2: After `rst` falls, `link_rst_n` stays low for RST_HOLD (default 8) rising edges and rises at the RST_HOLD-th edge. The first frame starts at the following edge. `sync` and `sdo` stay low while `link_rst_n` is low.
- R3: A frame is 256 bit clocks. `sync` is high for its first 16 bit clocks and low for the remaining 240. Frames repeat with no gap.
- R4: `sync` and `sdo` change only on rising edges of `bclk`. `sdi` is sampled on the falling edge in the middle of each bit.
- R5: The playback line carries the 16-bit tag, then slots 1 to 12, each MSB first. Slot k is taken from `tx_data[(13-k)*20-1 -: 20]`, so slot 1 comes from bits 239:220 and slot 12 from bits 19:0.
- R6: The tag is built as follows:
  - tag bit 15 is the OR of all `tx_valid` bits;
  - tag bit 15-k equals `tx_valid[k-1]` for k = 1..12;
  - tag bits 2:0 are zero.
- R7: A data slot whose `tx_valid` bit is clear is sent as twenty zero bits.
- R8: `tx_data` and `tx_valid` are captured at the rising edge that starts a frame. Changes after that edge do not affect the frame in flight.
- R9: At the rising edge that ends a frame (the edge that starts the next frame), `rx_tag` takes the first 16 captured bits and `rx_data` takes the remaining 240 bits, in arrival order with MSB first. `frame_done` is high for exactly that one cycle. Both parallel outputs hold until the next frame ends.
- R10: Raising `rst` in the middle of a frame abandons that frame without a `frame_done` pulse. The reset sequence of R2 then restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock sourced by the codec |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 240 | Playback slots 1..12, slot 1 in the top bits |
| tx_valid | input | 12 | Valid mask, bit k-1 for slot k |
| rx_tag | output | 16 | Tag slot of the last completed capture frame |
| rx_data | output | 240 | Slots 1..12 of the last completed capture frame |
| frame_done | output | 1 | One-cycle strobe when a capture frame completes |
| link_rst_n | output | 1 | Active-low reset to the codec |
| sync | output | 1 | Frame sync to the codec |
| sdo | output | 1 | Playback serial data |
| sdi | input | 1 | Capture serial data |

## Verification
A wrong frame position shows up on `sync` within one bit clock: the high pulse either moves or changes width. The same fault shifts every playback bit, so `sdo` differs from the reference at the next data bit.

A fault in the tag or slot gating shows on `sdo` in the bit where that field is sent. A capture fault, such as sampling on the wrong edge or misordered shifting, stays hidden until the end of the frame, up to 256 cycles later. It then appears as a whole-frame mismatch on `rx_tag` or `rx_data` when `frame_done` fires.

The reference model tracks reset hold, frame start and mid-frame aborts cycle by cycle. Any off-by-one in the reset counter therefore moves the first `sync` edge and is flagged at once.

// File: rtl/slotlink_pkg.sv
package slotlink_pkg;
  localparam int TAG_BITS  = 16;
  localparam int DATA_SLOTS = 12;
  localparam int SLOT_BITS = 20;

  function automatic int frame_bits(input int tag_w, input int n, input int slot_w);
    return tag_w + n * slot_w;
  endfunction
endpackage

// File: rtl/slotlink_rstseq.sv
module slotlink_rstseq #(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst,
  output logic link_rst_n,
  output logic run
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      link_rst_n <= 1'b0;
      run        <= 1'b0;
    end else if (!link_rst_n) begin
      if (cnt == CW'(HOLD - 1)) link_rst_n <= 1'b1;
      else                      cnt <= cnt + 1'b1;
    end else begin
      run <= 1'b1;
    end
  end

  p_run_after_release_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> link_rst_n);
endmodule

// File: rtl/slotlink_tx.sv
module slotlink_tx #(
  parameter int TAG_W  = 16,
  parameter int N      = 12,
  parameter int SLOT_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              run,
  input  logic [N*SLOT_W-1:0] tx_data,
  input  logic [N-1:0]      tx_valid,
  output logic              sdo
);
  localparam int DW = N * SLOT_W;
  localparam int FL = TAG_W + DW;

  logic [DW-1:0] gate;
  logic [TAG_W-1:0] tag;
  logic [FL-1:0] word, sr;

  for (genvar k = 0; k < N; k++) begin : g_gate
    assign gate[(N-k)*SLOT_W-1 -: SLOT_W] = {SLOT_W{tx_valid[k]}};
  end

  always_comb begin
    tag = '0;
    tag[TAG_W-1] = |tx_valid;
    for (int k = 0; k < N; k++) tag[TAG_W-2-k] = tx_valid[k];
    word = {tag, tx_data & gate};
  end

  always_ff @(posedge clk) begin
    if (rst)       sr <= '0;
    else if (load) sr <= word;
    else if (run)  sr <= sr << 1;
  end

  assign sdo = sr[FL-1];
endmodule

// File: rtl/slotlink_rx.sv
module slotlink_rx #(
  parameter int TAG_W = 16,
  parameter int DW    = 240
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             last,
  input  logic             sdi,
  output logic [TAG_W-1:0] rx_tag,
  output logic [DW-1:0]    rx_data,
  output logic             done
);
  localparam int FL = TAG_W + DW;

  logic          sdi_n;
  logic [FL-2:0] sr;
  logic [FL-1:0] full;

  always_ff @(negedge clk) begin
    if (rst) sdi_n <= 1'b0;
    else     sdi_n <= sdi;
  end

  assign full = {sr, sdi_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      rx_tag  <= '0;
      rx_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= run && last;
      if (run) sr <= {sr[FL-3:0], sdi_n};
      if (run && last) begin
        rx_tag  <= full[FL-1 -: TAG_W];
        rx_data <= full[DW-1:0];
      end
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/slotlink_ctrl.sv
module slotlink_ctrl
  import slotlink_pkg::*;
#(
  parameter int RST_HOLD = 8,
  parameter int TAG_W    = TAG_BITS,
  parameter int N        = DATA_SLOTS,
  parameter int SLOT_W   = SLOT_BITS
) (
  input  logic                bclk,
  input  logic                rst,
  input  logic [N*SLOT_W-1:0] tx_data,
  input  logic [N-1:0]        tx_valid,
  output logic [TAG_W-1:0]    rx_tag,
  output logic [N*SLOT_W-1:0] rx_data,
  output logic                frame_done,
  output logic                link_rst_n,
  output logic                sync,
  output logic                sdo,
  input  logic                sdi
);
  localparam int FL = frame_bits(TAG_W, N, SLOT_W);
  localparam int PW = $clog2(FL);

  logic          run, first, last, load;
  logic [PW-1:0] pos;

  slotlink_rstseq #(.HOLD(RST_HOLD)) u_rst (
    .clk(bclk), .rst(rst), .link_rst_n(link_rst_n), .run(run));

  assign first = link_rst_n && !run;
  assign last  = run && (pos == PW'(FL - 1));
  assign load  = first || last;

  always_ff @(posedge bclk) begin
    if (rst) begin
      pos  <= '0;
      sync <= 1'b0;
    end else begin
      if (load)     pos <= '0;
      else if (run) pos <= pos + 1'b1;
      if (load)                               sync <= 1'b1;
      else if (run && pos == PW'(TAG_W - 1))  sync <= 1'b0;
    end
  end

  slotlink_tx #(.TAG_W(TAG_W), .N(N), .SLOT_W(SLOT_W)) u_tx (
    .clk(bclk), .rst(rst), .load(load), .run(run),
    .tx_data(tx_data), .tx_valid(tx_valid), .sdo(sdo));

  slotlink_rx #(.TAG_W(TAG_W), .DW(N*SLOT_W)) u_rx (
    .clk(bclk), .rst(rst), .run(run), .last(last), .sdi(sdi),
    .rx_tag(rx_tag), .rx_data(rx_data), .done(frame_done));

  p_quiet_in_reset_r2: assert property (@(posedge bclk) disable iff (rst)
    !link_rst_n |-> (!sync && !sdo));
  p_sync_start_r2: assert property (@(posedge bclk) disable iff (rst)
    $rose(link_rst_n) |=> sync);
  p_sync_width_r3: assert property (@(posedge bclk) disable iff (rst)
    $fell(sync) |-> (pos == PW'(TAG_W)));
  p_done_align_r9: assert property (@(posedge bclk) disable iff (rst)
    frame_done |-> (sync && pos == '0));
endmodule

// File: tb/sim_slotlink_ctrl.sv
module sim_slotlink_ctrl;
  localparam int HOLD = 8;

  logic         bclk = 1'b0;
  logic         rst = 1'b1;
  logic [239:0] tx_data = '0;
  logic [11:0]  tx_valid = '0;
  logic [15:0]  rx_tag;
  logic [239:0] rx_data;
  logic         frame_done, link_rst_n, sync, sdo;
  logic         sdi = 1'b0;

  slotlink_ctrl #(.RST_HOLD(HOLD)) u0 (
    .bclk(bclk), .rst(rst), .tx_data(tx_data), .tx_valid(tx_valid),
    .rx_tag(rx_tag), .rx_data(rx_data), .frame_done(frame_done),
    .link_rst_n(link_rst_n), .sync(sync), .sdo(sdo), .sdi(sdi));

  always #2 bclk = ~bclk;

  int vectors = 0, fails = 0;
  bit finished = 0;

  // reference model state
  bit           m_lrn, m_run, m_done;
  int           m_rc, m_pos;
  logic [255:0] m_tx, m_cap, codec;
  logic [15:0]  m_rxt;
  logic [239:0] m_rxd;
  bit           changed, aborted;
  string        phase = "R1";

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] build();
    logic [255:0] w = '0;
    int base = 0;
    w[255] = |tx_valid;
    for (int k = 1; k <= 12; k++) begin
      w[255 - k] = tx_valid[k-1];
      if (tx_valid[k-1]) begin
        for (int b = 0; b < 20; b++) begin
          base = (12 - k) * 20 + b;
          w[base] = tx_data[base];
        end
      end
    end
    return w;
  endfunction

  task automatic randomize_inputs(input int mode);
    for (int i = 0; i < 8; i++) tx_data[i*30 +: 30] = 30'($urandom);
    case (mode)
      1: tx_valid = '0;
      2: tx_valid = '1;
      default: tx_valid = 12'($urandom);
    endcase
  endtask

  task automatic step(input int mode, input bit do_change);
    logic sdi_prev;
    string st;
    @(posedge bclk);
    #1;
    sdi_prev = sdi;
    if (rst) begin
      m_lrn = 0; m_rc = 0; m_run = 0; m_pos = 0; m_done = 0;
      m_rxt = '0; m_rxd = '0; m_tx = '0;
    end else begin
      m_done = 0;
      if (!m_lrn) begin
        if (m_rc == HOLD - 1) m_lrn = 1; else m_rc++;
      end else if (!m_run) begin
        m_run = 1; m_pos = 0; m_tx = build(); changed = 0;
        for (int i = 0; i < 8; i++) codec[i*32 +: 32] = $urandom;
      end else begin
        m_cap[255 - m_pos] = sdi_prev;
        if (m_pos == 255) begin
          m_rxt = m_cap[255:240]; m_rxd = m_cap[239:0]; m_done = 1;
          m_pos = 0; m_tx = build(); changed = 0; aborted = 0;
          for (int i = 0; i < 8; i++) codec[i*32 +: 32] = $urandom;
        end else m_pos++;
      end
    end
    if (rst) phase = "R1";
    else if (aborted) phase = "R10";
    else phase = "";
    chk({phase, " R2 link_rst_n"}, 256'(link_rst_n), 256'(m_lrn));
    chk({phase, " R3 sync"}, 256'(sync), 256'(m_run && m_pos < 16));
    if (!m_run) st = "R2 sdo idle";
    else if (m_pos < 16) st = "R6 tag bit";
    else if (!m_tx[255 - 1 - (m_pos - 16) / 20]) st = "R7 invalid slot bit";
    else st = changed ? "R8 R5 slot bit" : "R5 slot bit";
    chk({phase, " ", st}, 256'(sdo), 256'(m_run ? m_tx[255 - m_pos] : 1'b0));
    chk({phase, " R9 frame_done"}, 256'(frame_done), 256'(m_done));
    chk({phase, " R4 R9 rx_tag"}, 256'(rx_tag), 256'(m_rxt));
    chk({phase, " R4 R9 rx_data"}, 256'(rx_data), 256'(m_rxd));
    if (do_change) begin
      randomize_inputs(mode);
      if (m_run) changed = 1;
    end
    sdi = m_run ? codec[255 - m_pos] : 1'($urandom);
  endtask

  task automatic run_cycles(input int n, input int mode);
    for (int c = 0; c < n; c++) step(mode, (c % 53) == 17);
  endtask

  initial begin
    randomize_inputs(0);
    rst = 1;
    for (int c = 0; c < 3; c++) step(0, 0);
    rst = 0;
    run_cycles(HOLD + 4 * 256, 0);
    randomize_inputs(1);
    run_cycles(300, 1);
    randomize_inputs(2);
    run_cycles(300, 2);
    run_cycles(400, 0);
    rst = 1;
    step(0, 0);
    step(0, 0);
    rst = 0;
    aborted = 1;
    run_cycles(HOLD + 3 * 256 + 10, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule